// File: doc/BRIEF.md
# Platform Acceptance Fence Controller

This block sits between the load/store issue stage of a processor and the port that starts data accesses on the external platform bus. It tracks two kinds of work still in flight: uncacheable loads that are not write-coalescing, called sequential loads here, which are finished when their data comes back, and stores, which are finished when the platform signals that it has accepted them. When an acceptance fence is requested, the block holds back every later access at the bus edge. It releases them only once all earlier tracked work has finished, and it marks that point with a single-cycle done pulse.

Write-coalescing loads and untracked accesses pass through the gate like any other access. They are never counted, so they cannot hold a fence back. The fence guarantees acceptance by the platform only. It gives no guarantee that other coherent agents have observed earlier cacheable traffic. Software that needs that guarantee must follow this fence with a full memory fence, which is handled outside this block.

Top module: `plat_fence_gate`

## Requirements
- R1: While a fence is pending, `issue_ready_o` is low whatever the value of `plat_ready_i`. At all other times it equals `plat_ready_i`. An access issues in a cycle where `req_valid_i` and `issue_ready_o` are both high.
- R2: An issued access with `req_kind_i` = 2'b00 (sequential load) adds one to the load count, and each `ld_ret_i` pulse removes one. A pending fence does not complete while the load count is non-zero.
- R3: An issued access with `req_kind_i` = 2'b10 (store) adds one to the store count, and each `st_acc_i` pulse removes one. A pending fence does not complete while the store count is non-zero.
- R4: An access with kind 2'b01 (write-coalescing load) or 2'b11 (untracked) changes neither count and never delays a fence.
- R5: If an issue and a completion pulse for the same non-zero count fall in one cycle, that count stays unchanged.
- R6: In the cycle after a cycle in which a fence is pending and both counts are zero, `fence_done_o` is high for exactly that one cycle. The gate is open from that same cycle.
- R7: A fence request whose counts will both be zero at the end of its own cycle raises `fence_done_o` in the next cycle and never drives `issue_ready_o` low.
- R8: A fence request that arrives while a fence is pending merges into it. Together they produce one done pulse.
- R9: Each count is 6 bits wide and saturates at 63. An issue that would go past 63 leaves the count at 63.
- R10: A completion pulse that arrives while its count is zero is ignored and sets `err_o`. Once set, `err_o` stays high until reset.
- R11: After reset, both counts are zero, no fence is pending, `fence_done_o` and `err_o` are low, and `issue_ready_o` follows `plat_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An access wants to start on the platform bus |
| req_kind_i | input | 2 | Access type: 00 sequential load, 01 write-coalescing load, 10 store, 11 untracked |
| plat_ready_i | input | 1 | Platform interface can take an access |
| ld_ret_i | input | 1 | Pulse: one sequential load has returned its data |
| st_acc_i | input | 1 | Pulse: one store has been accepted by the platform |
| fence_req_i | input | 1 | Pulse: request an acceptance fence |
| issue_ready_o | output | 1 | Gated ready back to the issue logic |
| fence_done_o | output | 1 | Single-cycle pulse: the fence has drained |
| err_o | output | 1 | Sticky flag for a completion pulse that had no matching outstanding access |

## Verification
The bench aims at cycle alignment around the drain. It checks that the done pulse lands exactly one cycle after the counts reach zero, and that the gate reopens in that same cycle. A design that compares the next-state count, or that releases the gate one cycle late, fails on the first drain. Issue and completion in the same cycle are driven on purpose, because a counter that drops either term leaves a fence hung or lets it finish early. Fences that are already drained, back-to-back fence requests, 65 stores in a row against the 63 ceiling, and a stray completion at count zero round out the cases. Each of these exposes, in turn, a fast path that blocks an issue slot, a doubled done pulse, a count that wraps to zero, and an error flag that is lost or that corrupts a count.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
   typedef enum logic [1:0] {
      ACC_SEQ_LD    = 2'b00,
      ACC_WC_LD     = 2'b01,
      ACC_STORE     = 2'b10,
      ACC_UNTRACKED = 2'b11
   } acc_kind_e;

   localparam int unsigned TRACK_N = 2;   // tracked classes: seq loads, stores
endpackage

// File: rtl/pfg_track_cnt.sv
module pfg_track_cnt #(
   parameter int unsigned CNT_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic cpl_i,
   output logic zero_o,
   output logic zero_nxt_o,
   output logic err_o
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("pfg_track_cnt: CNT_W must lie in 2..16");
   end

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             dec, stray;
   logic             err_q;

   assign dec   = cpl_i && (cnt_q != '0);
   assign stray = cpl_i && (cnt_q == '0);

   always_comb begin
      cnt_nxt = cnt_q;
      if (inc_i && !dec) begin
         cnt_nxt = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
      end else if (!inc_i && dec) begin
         cnt_nxt = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         err_q <= err_q | stray;
      end
   end

   assign zero_o     = (cnt_q == '0);
   assign zero_nxt_o = (cnt_nxt == '0);
   assign err_o      = err_q;

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CMAX && inc_i && !cpl_i) |=> (cnt_q == CMAX)); // R9
   AST_PAIR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && cpl_i && cnt_q != '0) |=> $stable(cnt_q)); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R10
   AST_STRAY_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (stray && !inc_i) |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/pfg_fence_seq.sv
module pfg_fence_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic fence_req_i,
   input  logic drained_now_i,
   input  logic drained_nxt_i,
   output logic pending_o,
   output logic done_o
);
   logic pend_q, pend_nxt;
   logic done_q, done_nxt;

   always_comb begin
      pend_nxt = pend_q;
      done_nxt = 1'b0;
      if (pend_q) begin
         // later requests merge into the open fence
         if (drained_now_i) begin
            pend_nxt = 1'b0;
            done_nxt = 1'b1;
         end
      end else if (fence_req_i) begin
         if (drained_nxt_i) begin
            done_nxt = 1'b1;
         end else begin
            pend_nxt = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         pend_q <= pend_nxt;
         done_q <= done_nxt;
      end
   end

   assign pending_o = pend_q;
   assign done_o    = done_q;

   AST_HOLD_UNTIL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !drained_now_i) |=> !done_q); // R2
   AST_MERGE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && drained_now_i) |=> (done_q && !pend_q)); // R8
endmodule

// File: rtl/plat_fence_gate.sv
module plat_fence_gate #(
   parameter int unsigned CNT_W = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid_i,
   input  logic [1:0] req_kind_i,
   input  logic       plat_ready_i,
   input  logic       ld_ret_i,
   input  logic       st_acc_i,
   input  logic       fence_req_i,
   output logic       issue_ready_o,
   output logic       fence_done_o,
   output logic       err_o
);
   import pfg_pkg::*;

   localparam int unsigned NT = TRACK_N;

   logic          pending;
   logic          issue;
   logic [NT-1:0] inc_v, cpl_v, zero_v, zero_nxt_v, err_v;

   assign issue_ready_o = plat_ready_i && !pending;
   assign issue         = req_valid_i && issue_ready_o;

   for (genvar gi = 0; gi < NT; gi++) begin : g_trk
      localparam acc_kind_e KIND = (gi == 0) ? ACC_SEQ_LD : ACC_STORE;
      assign inc_v[gi] = issue && (req_kind_i == KIND);
      assign cpl_v[gi] = (gi == 0) ? ld_ret_i : st_acc_i;

      pfg_track_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk        (clk),
         .rst_n      (rst_n),
         .inc_i      (inc_v[gi]),
         .cpl_i      (cpl_v[gi]),
         .zero_o     (zero_v[gi]),
         .zero_nxt_o (zero_nxt_v[gi]),
         .err_o      (err_v[gi])
      );
   end

   pfg_fence_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .fence_req_i   (fence_req_i),
      .drained_now_i (&zero_v),
      .drained_nxt_i (&zero_nxt_v),
      .pending_o     (pending),
      .done_o        (fence_done_o)
   );

   assign err_o = |err_v;

   AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> !issue_ready_o); // R1
   AST_DONE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done_o |-> !pending); // R6
   AST_FAST_NOBLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && fence_req_i && (&zero_nxt_v)) |=> (!pending && fence_done_o)); // R7
   AST_EXEMPT_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_kind_i[0] && !ld_ret_i && !st_acc_i) |=> $stable(zero_v)); // R4
endmodule

// File: tb/plat_fence_gate_bench.sv
module plat_fence_gate_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid_i = 1'b0;
   logic [1:0] req_kind_i = 2'b00;
   logic       plat_ready_i = 1'b0;
   logic       ld_ret_i = 1'b0;
   logic       st_acc_i = 1'b0;
   logic       fence_req_i = 1'b0;
   logic       issue_ready_o, fence_done_o, err_o;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   int m_ld = 0, m_st = 0;
   bit m_pend = 0, m_done = 0, m_err = 0;

   always #10 clk = ~clk;   // 50 MHz

   plat_fence_gate u_plat_fence_gate (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
      .plat_ready_i(plat_ready_i), .ld_ret_i(ld_ret_i), .st_acc_i(st_acc_i),
      .fence_req_i(fence_req_i), .issue_ready_o(issue_ready_o),
      .fence_done_o(fence_done_o), .err_o(err_o)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int nxt_cnt(input int c, input bit inc, input bit cpl);
      bit dec = cpl && (c != 0);
      if (inc && !dec) return (c == 63) ? 63 : c + 1;
      if (!inc && dec) return c - 1;
      return c;
   endfunction

   // entered and left at a falling edge
   task automatic step(input logic v, input logic [1:0] k, input logic pr,
                       input logic lr, input logic sa, input logic fr);
      bit rdy, iss;
      int ld_n, st_n;
      bit pend_n, done_n, err_n;
      req_valid_i = v; req_kind_i = k; plat_ready_i = pr;
      ld_ret_i = lr; st_acc_i = sa; fence_req_i = fr;
      #1;
      rdy = pr && !m_pend;
      chk("R1", issue_ready_o, rdy);
      chk("R6", fence_done_o, m_done);
      chk("R10", err_o, m_err);
      iss   = v && rdy;
      ld_n  = nxt_cnt(m_ld, iss && k == 2'b00, lr);
      st_n  = nxt_cnt(m_st, iss && k == 2'b10, sa);
      err_n = m_err || (lr && m_ld == 0) || (sa && m_st == 0);
      pend_n = 0; done_n = 0;
      if (m_pend) begin
         if (m_ld == 0 && m_st == 0) done_n = 1; else pend_n = 1;
      end else if (fr) begin
         if (ld_n == 0 && st_n == 0) done_n = 1; else pend_n = 1;
      end
      @(posedge clk);
      m_ld = ld_n; m_st = st_n; m_pend = pend_n; m_done = done_n; m_err = err_n;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 2'b00, 1, 0, 0, 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!ended) begin
         ended = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int pulses;
      void'($urandom(32'd1234));
      plat_ready_i = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk("R11", issue_ready_o, 1'b1);
      chk("R11", fence_done_o, 1'b0);
      chk("R11", err_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", issue_ready_o, 1'b1);

      // R2: two sequential loads, then fence
      step(1, 2'b00, 1, 0, 0, 0);
      step(1, 2'b00, 1, 0, 0, 0);
      step(0, 2'b00, 1, 0, 0, 1);
      chk("R1", issue_ready_o, 1'b0);
      step(1, 2'b10, 1, 1, 0, 0);
      chk("R2", fence_done_o, 1'b0);
      step(0, 2'b00, 1, 1, 0, 0);
      chk("R2", fence_done_o, 1'b0);
      step(0, 2'b00, 1, 0, 0, 0);
      chk("R2", fence_done_o, 1'b1);
      idle(2);

      // R3: stores drained by acceptance pulses
      step(1, 2'b10, 1, 0, 0, 0);
      step(0, 2'b00, 1, 0, 0, 1);
      chk("R3", fence_done_o, 1'b0);
      step(0, 2'b00, 1, 0, 1, 0);
      step(0, 2'b00, 1, 0, 0, 0);
      chk("R3", fence_done_o, 1'b1);
      idle(2);

      // R4: exempt kinds do not delay the fence
      step(1, 2'b01, 1, 0, 0, 0);
      step(1, 2'b11, 1, 0, 0, 1);
      chk("R4", fence_done_o, 1'b1);
      idle(2);

      // R5: issue and return together on a non-zero count
      step(1, 2'b00, 1, 0, 0, 0);
      step(1, 2'b00, 1, 1, 0, 0);
      step(0, 2'b00, 1, 0, 0, 1);
      step(0, 2'b00, 1, 1, 0, 0);
      step(0, 2'b00, 1, 0, 0, 0);
      chk("R5", fence_done_o, 1'b1);
      idle(2);

      // R7: fence on an empty block
      step(0, 2'b00, 1, 0, 0, 1);
      chk("R7", fence_done_o, 1'b1);
      chk("R7", issue_ready_o, 1'b1);
      idle(2);

      // R8: merged fence requests give one pulse
      step(1, 2'b10, 1, 0, 0, 0);
      step(0, 2'b00, 1, 0, 0, 1);
      step(0, 2'b00, 1, 0, 0, 1);
      pulses = 0;
      step(0, 2'b00, 1, 0, 1, 1);
      for (int i = 0; i < 4; i++) begin
         if (fence_done_o) pulses++;
         step(0, 2'b00, 1, 0, 0, 0);
      end
      chk("R8", pulses == 1, 1'b1);
      idle(2);

      // R9: 65 stores saturate at 63
      for (int i = 0; i < 65; i++) step(1, 2'b10, 1, 0, 0, 0);
      for (int i = 0; i < 62; i++) step(0, 2'b00, 1, 0, 1, 0);
      step(0, 2'b00, 1, 0, 0, 1);
      step(0, 2'b00, 1, 0, 0, 0);
      chk("R9", fence_done_o, 1'b0);
      step(0, 2'b00, 1, 0, 1, 0);
      step(0, 2'b00, 1, 0, 0, 0);
      chk("R9", fence_done_o, 1'b1);
      idle(2);

      // constrained random traffic, completions only against outstanding work
      for (int i = 0; i < 3000; i++) begin
         logic v, pr, lr, sa, fr;
         logic [1:0] k;
         v  = ($urandom % 3) != 0;
         k  = 2'($urandom);
         pr = ($urandom % 5) != 0;
         lr = (m_ld != 0) && ($urandom % 3 == 0);
         sa = (m_st != 0) && ($urandom % 3 == 0);
         fr = ($urandom % 23) == 0;
         step(v, k, pr, lr, sa, fr);
      end
      while (m_ld != 0 || m_st != 0) step(0, 2'b00, 1, m_ld != 0, m_st != 0, 0);
      idle(3);

      // R10: stray return at zero
      step(0, 2'b00, 1, 1, 0, 0);
      chk("R10", err_o, 1'b1);
      step(0, 2'b00, 1, 0, 0, 1);
      chk("R10", fence_done_o, 1'b1);
      idle(2);
      chk("R10", err_o, 1'b1);

      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule